// File: doc/BRIEF.md
# Fractional Seconds Counter with Alarm

This block keeps wall-clock time in a low-power domain. A single wide count advances once per clock. Its upper field holds whole seconds and its lower field holds the fraction of the current second. Software loads a start time through a simple register write port. The block counts only while its run control bit is set, no overflow is pending, and two freeze inputs are low. The neighbouring supervision logic drives those inputs, one for a non-valid condition and one for a failure state.

A seconds-resolution alarm register is compared each time the fraction wraps to a new second. An exact match sets a sticky alarm flag. That flag, gated by an interrupt-enable bit, drives the interrupt output. When the count reaches its maximum value, it stops there and raises an overflow flag. Software clears either flag by writing a one to the flag's bit position.

Top module: `rtc_frac_alarm`

## Requirements
- R1: After reset, all of the following read zero: seconds (address 0), fraction (address 1), control (address 4), status (address 5) and interrupt enable (address 6). Alarm seconds (address 2) reads all ones, and `alarm_irq` is low.
- R2: When the block is running, the fraction field increases by one on every clock. When the fraction is at its maximum, it returns to zero and the seconds field increases by one.
- R3: The count holds its value whenever any one of these holds: control bit 3 is clear, the overflow flag is set, `hold_nonvalid` is high, or `hold_failure` is high. A write of control bit 3 acts from the next clock on.
- R4: A write to address 0 loads the seconds field and sets the fraction to zero on the same clock. A write to address 1 loads the fraction field from the low FRAC_W data bits. A register write takes priority over counting on that clock.
- R5: A write to address 2 sets the alarm seconds. Status bit 4 (the alarm flag) sets only when the fraction wraps to zero and the new seconds value exactly equals the alarm seconds. The flag then stays set, and it sets only once for each match.
- R6: Writing to address 5 clears status bit 4 or bit 2 when the matching data bit is one. Writing zero to a bit leaves that flag unchanged.
- R7: `alarm_irq` is high exactly when status bit 4 and interrupt-enable bit 4 (address 6) are both set. No other interrupt-enable bit is stored.
- R8: When the block is running at the all-ones count, the next clock sets status bit 2 and the count stays at all ones instead of wrapping.
- R9: Address 3, the alarm fraction, always reads zero, and writes to it have no effect.
- R10: Control bit 2, the monotonic enable, is stored and reads back, but it does not affect counting. Control reads return only bits 3 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data |
| hold_nonvalid | input | 1 | Freeze request from the non-valid condition |
| hold_failure | input | 1 | Freeze request from the failure state |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions check the following on every cycle:
- a stopped count holds;
- a running fraction steps by exactly one;
- a seconds load starts on a whole-second boundary;
- the alarm flag rises only at a rollover whose seconds equal the alarm value, and stays set until cleared;
- the interrupt stays low while it is masked;
- overflow appears only at the all-ones count.

Only the bench scenarios can show the rest. These cover the reset values, read-back masking of each register, the exact cycle on which the alarm fires and the fact that it does not fire again. They also cover the one extra count step when the run bit is cleared, the effect of each freeze input, and recovery after an overflow.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_SEC    = 3'd0;
   localparam logic [ADDR_W-1:0] A_FRAC   = 3'd1;
   localparam logic [ADDR_W-1:0] A_ALMSEC = 3'd2;
   localparam logic [ADDR_W-1:0] A_ALMFRC = 3'd3;
   localparam logic [ADDR_W-1:0] A_CTL    = 3'd4;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
   localparam logic [ADDR_W-1:0] A_IEN    = 3'd6;

   localparam int CTL_RUN_BIT  = 3;
   localparam int CTL_MONO_BIT = 2;
   localparam int ST_ALM_BIT   = 4;
   localparam int ST_OVF_BIT   = 2;
   localparam int IE_ALM_BIT   = 4;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req,
   input  logic              sec_we,
   input  logic              frac_we,
   input  logic              ovf_clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [SEC_W-1:0]  sec_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic [SEC_W-1:0]  sec_next,
   output logic              ovf_q,
   output logic              roll
);
   logic frac_top;
   logic sec_top;
   logic running;
   logic any_we;
   logic hit_ceiling;

   assign frac_top    = &frac_q;
   assign sec_top     = &sec_q;
   assign running     = run_req & ~ovf_q;
   assign any_we      = sec_we | frac_we;
   assign sec_next    = sec_q + 1'b1;
   assign roll        = running & frac_top & ~sec_top & ~any_we;
   assign hit_ceiling = running & frac_top & sec_top & ~any_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         frac_q <= '0;
      end else if (sec_we) begin
         sec_q  <= wdata[SEC_W-1:0];
         frac_q <= '0;
      end else if (frac_we) begin
         frac_q <= wdata[FRAC_W-1:0];
      end else if (running && !hit_ceiling) begin
         frac_q <= frac_q + 1'b1;
         if (frac_top) begin
            sec_q <= sec_next;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (hit_ceiling) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
   parameter int SEC_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alm_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              roll,
   input  logic [SEC_W-1:0]  sec_next,
   input  logic              flag_clr,
   output logic [SEC_W-1:0]  alarm_sec_q,
   output logic              flag_q
);
   logic match;

   assign match = roll & (sec_next == alarm_sec_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_sec_q <= '1;
      end else if (alm_we) begin
         alarm_sec_q <= wdata[SEC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [SEC_W-1:0]  sec_q,
   input  logic [FRAC_W-1:0] frac_q,
   input  logic [SEC_W-1:0]  alarm_sec_q,
   input  logic              alarm_flag,
   input  logic              ovf_q,
   output logic              sec_we,
   output logic              frac_we,
   output logic              alm_we,
   output logic              clr_alarm,
   output logic              clr_ovf,
   output logic              ctl_run,
   output logic              ctl_mono,
   output logic              ie_alarm
);
   logic              ctl_we;
   logic              ien_we;
   logic              stat_we;
   logic [DATA_W-1:0] rd_mux;

   assign sec_we    = wr_en && (wr_addr == A_SEC);
   assign frac_we   = wr_en && (wr_addr == A_FRAC);
   assign alm_we    = wr_en && (wr_addr == A_ALMSEC);
   assign ctl_we    = wr_en && (wr_addr == A_CTL);
   assign stat_we   = wr_en && (wr_addr == A_STAT);
   assign ien_we    = wr_en && (wr_addr == A_IEN);
   assign clr_alarm = stat_we && wr_data[ST_ALM_BIT];
   assign clr_ovf   = stat_we && wr_data[ST_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_run  <= 1'b0;
         ctl_mono <= 1'b0;
      end else if (ctl_we) begin
         ctl_run  <= wr_data[CTL_RUN_BIT];
         ctl_mono <= wr_data[CTL_MONO_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_alarm <= 1'b0;
      end else if (ien_we) begin
         ie_alarm <= wr_data[IE_ALM_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (rd_addr)
         A_SEC:    rd_mux = DATA_W'(sec_q);
         A_FRAC:   rd_mux = DATA_W'(frac_q);
         A_ALMSEC: rd_mux = DATA_W'(alarm_sec_q);
         A_ALMFRC: rd_mux = '0;
         A_CTL: begin
            rd_mux[CTL_RUN_BIT]  = ctl_run;
            rd_mux[CTL_MONO_BIT] = ctl_mono;
         end
         A_STAT: begin
            rd_mux[ST_ALM_BIT] = alarm_flag;
            rd_mux[ST_OVF_BIT] = ovf_q;
         end
         A_IEN:    rd_mux[IE_ALM_BIT] = ie_alarm;
         default:  rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else begin
               rd_data <= rd_mux;
            end
         end
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/rtc_frac_alarm.sv
module rtc_frac_alarm
   import rtc_pkg::*;
#(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              hold_nonvalid,
   input  logic              hold_failure,
   output logic              alarm_irq
);
   localparam int TOTAL_W = SEC_W + FRAC_W;

   generate
      if (SEC_W < 1 || SEC_W > DATA_W) begin : g_bad_sec
         $error("SEC_W must lie between 1 and the data width");
      end
      if (FRAC_W < 1 || FRAC_W > DATA_W) begin : g_bad_frac
         $error("FRAC_W must lie between 1 and the data width");
      end
      if (TOTAL_W > 2 * DATA_W) begin : g_bad_total
         $error("combined count is wider than two data words");
      end
   endgenerate

   logic [SEC_W-1:0]  sec_q;
   logic [FRAC_W-1:0] frac_q;
   logic [SEC_W-1:0]  sec_next;
   logic [SEC_W-1:0]  alarm_sec_q;
   logic              ovf_q;
   logic              roll;
   logic              alarm_flag;
   logic              sec_we;
   logic              frac_we;
   logic              alm_we;
   logic              clr_alarm;
   logic              clr_ovf;
   logic              ctl_run;
   logic              ctl_mono;
   logic              ie_alarm;
   logic              run_req;

   assign run_req   = ctl_run & ~hold_nonvalid & ~hold_failure;
   assign alarm_irq = alarm_flag & ie_alarm;

   rtc_regfile #(
      .SEC_W (SEC_W),
      .FRAC_W(FRAC_W),
      .RD_REG(RD_REG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .sec_q      (sec_q),
      .frac_q     (frac_q),
      .alarm_sec_q(alarm_sec_q),
      .alarm_flag (alarm_flag),
      .ovf_q      (ovf_q),
      .sec_we     (sec_we),
      .frac_we    (frac_we),
      .alm_we     (alm_we),
      .clr_alarm  (clr_alarm),
      .clr_ovf    (clr_ovf),
      .ctl_run    (ctl_run),
      .ctl_mono   (ctl_mono),
      .ie_alarm   (ie_alarm)
   );

   rtc_time_core #(
      .SEC_W (SEC_W),
      .FRAC_W(FRAC_W),
      .DATA_W(DATA_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_req (run_req),
      .sec_we  (sec_we),
      .frac_we (frac_we),
      .ovf_clr (clr_ovf),
      .wdata   (wr_data),
      .sec_q   (sec_q),
      .frac_q  (frac_q),
      .sec_next(sec_next),
      .ovf_q   (ovf_q),
      .roll    (roll)
   );

   rtc_alarm_unit #(
      .SEC_W (SEC_W),
      .DATA_W(DATA_W)
   ) u_alarm (
      .clk        (clk),
      .rst_n      (rst_n),
      .alm_we     (alm_we),
      .wdata      (wr_data),
      .roll       (roll),
      .sec_next   (sec_next),
      .flag_clr   (clr_alarm),
      .alarm_sec_q(alarm_sec_q),
      .flag_q     (alarm_flag)
   );
endmodule

// File: rtl/rtc_frac_alarm_chk.sv
module rtc_frac_alarm_chk #(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       wr_data,
   input logic              hold_nonvalid,
   input logic              hold_failure,
   input logic              alarm_irq,
   input logic [SEC_W-1:0]  sec_q,
   input logic [FRAC_W-1:0] frac_q,
   input logic [SEC_W-1:0]  alarm_sec_q,
   input logic              alarm_flag,
   input logic              ovf_q,
   input logic              sec_we,
   input logic              frac_we,
   input logic              clr_alarm,
   input logic              ctl_run,
   input logic              ie_alarm
);
   logic stopped;
   assign stopped = !ctl_run || ovf_q || hold_nonvalid || hold_failure;

   p_stopped_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && !sec_we && !frac_we |=> $stable(sec_q) && $stable(frac_q));

   p_frac_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stopped && !sec_we && !frac_we && !(&frac_q)
      |=> (frac_q == FRAC_W'($past(frac_q) + 1'b1)) && $stable(sec_q));

   p_load_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_we |=> (frac_q == '0) && (sec_q == $past(wr_data[SEC_W-1:0])));

   p_alarm_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> (frac_q == '0) && (sec_q == $past(alarm_sec_q)));

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_flag && !clr_alarm |=> alarm_flag);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_alarm |-> !alarm_irq);

   p_ovf_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> (&sec_q) && (&frac_q));
endmodule

bind rtc_frac_alarm rtc_frac_alarm_chk #(
   .SEC_W (SEC_W),
   .FRAC_W(FRAC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_data      (wr_data),
   .hold_nonvalid(hold_nonvalid),
   .hold_failure (hold_failure),
   .alarm_irq    (alarm_irq),
   .sec_q        (sec_q),
   .frac_q       (frac_q),
   .alarm_sec_q  (alarm_sec_q),
   .alarm_flag   (alarm_flag),
   .ovf_q        (ovf_q),
   .sec_we       (sec_we),
   .frac_we      (frac_we),
   .clr_alarm    (clr_alarm),
   .ctl_run      (ctl_run),
   .ie_alarm     (ie_alarm)
);

// File: tb/test_rtc_frac_alarm.sv
module test_rtc_frac_alarm;
   localparam int FW = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic [2:0]  rd_addr;
   logic [31:0] rd_data;
   logic        hold_nonvalid;
   logic        hold_failure;
   logic        alarm_irq;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   rtc_frac_alarm #(.SEC_W(32), .FRAC_W(FW), .RD_REG(1'b0)) i_rtc_frac_alarm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .hold_nonvalid(hold_nonvalid), .hold_failure(hold_failure),
      .alarm_irq(alarm_irq)
   );

   typedef struct packed {
      logic [2:0]  wa;
      logic [31:0] wd;
      logic [2:0]  ra;
      logic [31:0] exp;
   } vec_t;

   // Counter stopped (control bit 3 clear) for the whole table.
   localparam vec_t VEC [10] = '{
      '{3'd0, 32'h1234_5678, 3'd0, 32'h1234_5678}, // R4 seconds load
      '{3'd1, 32'h0000_0005, 3'd1, 32'h0000_0005}, // R4 fraction load
      '{3'd1, 32'h0000_FFF7, 3'd1, 32'h0000_0007}, // R4 low FRAC_W bits
      '{3'd0, 32'h0000_000A, 3'd1, 32'h0000_0000}, // R4 fraction cleared
      '{3'd2, 32'h0000_0055, 3'd2, 32'h0000_0055}, // R5 alarm seconds
      '{3'd3, 32'h0000_0009, 3'd3, 32'h0000_0000}, // R9 alarm fraction
      '{3'd4, 32'hFFFF_FFF4, 3'd4, 32'h0000_0004}, // R10 monotonic bit
      '{3'd6, 32'hFFFF_FFFF, 3'd6, 32'h0000_0010}, // R7 enable mask
      '{3'd6, 32'h0000_0000, 3'd6, 32'h0000_0000}, // R7 enable clear
      '{3'd5, 32'h0000_0014, 3'd0, 32'h0000_000A}  // R10 no count, R6
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      hold_nonvalid = 1'b0; hold_failure = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_rd("R1 seconds", 3'd0, 32'h0);
      chk_rd("R1 fraction", 3'd1, 32'h0);
      chk_rd("R1 alarm seconds", 3'd2, 32'hFFFF_FFFF);
      chk_rd("R1 control", 3'd4, 32'h0);
      chk_rd("R1 status", 3'd5, 32'h0);
      chk_rd("R1 irq enable", 3'd6, 32'h0);
      chk("R1 irq", {31'b0, alarm_irq}, 32'h0);

      for (int i = 0; i < 10; i++) begin
         wr(VEC[i].wa, VEC[i].wd);
         chk_rd($sformatf("table vector %0d", i), VEC[i].ra, VEC[i].exp);
      end

      // R2 counting and rollover
      wr(3'd0, 32'd10);
      wr(3'd4, 32'h8);
      idle(5);
      chk_rd("R2 fraction step", 3'd1, 32'd5);
      idle(11);
      chk_rd("R2 rollover seconds", 3'd0, 32'd11);
      chk_rd("R2 rollover fraction", 3'd1, 32'd0);

      // R3 stop conditions
      wr(3'd4, 32'h0);            // old run bit still counts this edge
      idle(4);
      chk_rd("R3 run bit clear", 3'd1, 32'd1);
      wr(3'd4, 32'h8);
      hold_nonvalid = 1'b1;
      idle(4);
      chk_rd("R3 non-valid hold", 3'd1, 32'd1);
      hold_nonvalid = 1'b0;
      idle(2);
      chk_rd("R3 resume after non-valid", 3'd1, 32'd3);
      hold_failure = 1'b1;
      idle(4);
      chk_rd("R3 failure hold", 3'd1, 32'd3);
      hold_failure = 1'b0;
      idle(1);
      chk_rd("R3 resume after failure", 3'd1, 32'd4);

      // R5 alarm, R6 clear, R7 interrupt
      wr(3'd4, 32'h0);
      wr(3'd2, 32'd20);
      wr(3'd0, 32'd19);
      wr(3'd1, 32'd13);
      wr(3'd6, 32'h10);
      wr(3'd4, 32'h8);
      chk("R5 no flag before match", {31'b0, alarm_irq}, 32'h0);
      idle(2);
      chk_rd("R5 flag clear at fraction max", 3'd5, 32'h0);
      idle(1);
      chk_rd("R5 match seconds", 3'd0, 32'd20);
      chk_rd("R5 flag set on match", 3'd5, 32'h10);
      chk("R7 irq with enable", {31'b0, alarm_irq}, 32'h1);
      idle(16);
      chk_rd("R5 flag sticky", 3'd5, 32'h10);
      wr(3'd5, 32'h0);
      chk_rd("R6 zero write keeps flag", 3'd5, 32'h10);
      wr(3'd6, 32'h0);
      chk("R7 irq masked", {31'b0, alarm_irq}, 32'h0);
      wr(3'd6, 32'h10);
      chk("R7 irq re-enabled", {31'b0, alarm_irq}, 32'h1);
      wr(3'd5, 32'h10);
      chk_rd("R6 one write clears flag", 3'd5, 32'h0);
      chk("R7 irq after clear", {31'b0, alarm_irq}, 32'h0);
      idle(40);
      chk_rd("R5 fires once", 3'd5, 32'h0);

      // R8 overflow freeze and recovery
      wr(3'd4, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd1, 32'd14);
      wr(3'd4, 32'h8);
      idle(1);
      chk_rd("R8 no overflow below ceiling", 3'd5, 32'h0);
      idle(1);
      chk_rd("R8 overflow flag", 3'd5, 32'h4);
      idle(3);
      chk_rd("R8 seconds frozen", 3'd0, 32'hFFFF_FFFF);
      chk_rd("R8 fraction frozen", 3'd1, 32'hF);
      wr(3'd0, 32'd5);
      wr(3'd5, 32'h4);
      chk_rd("R6 overflow cleared", 3'd5, 32'h0);
      idle(2);
      chk_rd("R3 counting after overflow clear", 3'd1, 32'd2);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule